// File: doc/BRIEF.md
# AES Key-Expansion Assist Unit

This block computes the helper word that an AES key schedule needs between two round keys. It takes a 128-bit source operand, which is normally the previous round key, and an 8-bit round constant. It returns a 128-bit result. Two of the source's 32-bit words pass through the forward AES substitution box. Each substituted word then also appears a second time, rotated by one byte and XORed with the round constant.

The unit performs only this single step. The surrounding logic folds the result into the previous key and chooses the next round constant. One operation is accepted on any cycle in which `start_i` is high. The result is registered and appears with `done_o` on the following cycle. Starts may arrive back to back, one per cycle.

Byte numbering follows the bit position: byte k of a 128-bit value occupies bits [8k+7:8k]. Word k occupies bits [32k+31:32k], so it holds bytes 4k..4k+3 with byte 4k least significant.

Top module: `kexp_assist`

## Requirements
- R1: After a synchronous reset, `done_o` is 0 and `result_o` is all zeros.
- R2: Result bytes 0, 1, 2 and 3 equal the forward S-box of source bytes 4, 5, 6 and 7 respectively.
- R3: Result bytes 8, 9, 10 and 11 equal the forward S-box of source bytes 12, 13, 14 and 15 respectively.
- R4: Result word 1 equals result word 0 rotated right by 8 bits within 32 bits, XORed with the immediate zero-extended to 32 bits.
- R5: Result word 3 equals result word 2 rotated right by 8 bits within 32 bits, XORed with the same zero-extended immediate.
- R6: The immediate changes only bits [39:32] and [103:96] of the result. Words 0 and 2, and the upper three bytes of words 1 and 3, do not depend on it.
- R7: Source bytes 0..3 and 8..11 have no effect on the result.
- R8: `done_o` is high in the cycle after each cycle in which `start_i` is high, and low otherwise. A start in every cycle yields a fresh result in every cycle.
- R9: While `start_i` is low, `result_o` holds its last value.
- R10: The S-box is the AES forward substitution: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (with 0 mapped to 0), followed by the AES affine transform with constant 0x63. For example, S(0x00)=0x63, S(0x01)=0x7C, S(0x53)=0xED and S(0xFF)=0x16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept an operation this cycle |
| src_i | input | 128 | Source operand (previous round key) |
| imm_i | input | 8 | Round-constant immediate |
| done_o | output | 1 | Result valid, one cycle after start |
| result_o | output | 128 | Registered assist result |

## Verification
The bench runs a full ten-step AES-128 key expansion through the unit and compares the derived round keys with the published expanded-key vectors. A swapped rotation direction, a wrong word pairing or a wrong S-box entry breaks every later round key. Directed cases alter only the ignored source bytes, or only the immediate, and confirm that nothing else moves. A design that read the wrong source words, or that XORed the immediate into the wrong byte or word, would show up there. A behavioural model built from log and antilog tables is compared on every clock. It catches S-box arithmetic errors, a missing or extra `done_o` pulse in back-to-back runs, and a result that drifts while the unit is idle.

// File: rtl/kexp_pkg.sv
package kexp_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int NUM_WORDS  = 4;
    localparam int BLOCK_W    = WORD_W * NUM_WORDS;
    localparam int IMM_W      = 8;
    localparam int NUM_LANES  = NUM_WORDS / 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // word 0 in the least significant position
    typedef struct packed {
        word_t w3;
        word_t w2;
        word_t w1;
        word_t w0;
    } block_t;

    localparam byte_t AFFINE_C = 8'h63;
    localparam byte_t POLY_LO  = 8'h1b;

    function automatic byte_t gf_dbl(input byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? POLY_LO : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // inverse as x^254 through an addition chain; 0 maps to 0
    function automatic byte_t gf_inv(input byte_t x);
        byte_t x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
        x2   = gf_mul(x, x);
        x3   = gf_mul(x2, x);
        x6   = gf_mul(x3, x3);
        x12  = gf_mul(x6, x6);
        x15  = gf_mul(x12, x3);
        x30  = gf_mul(x15, x15);
        x60  = gf_mul(x30, x30);
        x120 = gf_mul(x60, x60);
        x240 = gf_mul(x120, x120);
        x252 = gf_mul(x240, x12);
        return gf_mul(x252, x2);
    endfunction

    function automatic byte_t rotl_byte(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t fwd_sbox(input byte_t x);
        byte_t b;
        b = gf_inv(x);
        return b ^ rotl_byte(b, 1) ^ rotl_byte(b, 2) ^ rotl_byte(b, 3)
                 ^ rotl_byte(b, 4) ^ AFFINE_C;
    endfunction

endpackage

// File: rtl/kexp_sub_word.sv
module kexp_sub_word
    import kexp_pkg::*;
(
    input  word_t din,
    output word_t dout
);

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane_byte
        assign dout[g*BYTE_W +: BYTE_W] = fwd_sbox(din[g*BYTE_W +: BYTE_W]);
    end

endmodule

// File: rtl/kexp_rot_mix.sv
module kexp_rot_mix
    import kexp_pkg::*;
#(
    parameter int ROT_BITS = 8
) (
    input  word_t             sub_i,
    input  logic [IMM_W-1:0]  imm_i,
    output word_t             mix_o
);

    localparam int KEEP_W = WORD_W - ROT_BITS;

    word_t rotated;
    assign rotated = {sub_i[ROT_BITS-1:0], sub_i[WORD_W-1:ROT_BITS]};
    assign mix_o   = rotated ^ {{KEEP_W{1'b0}}, imm_i};

endmodule

// File: rtl/kexp_assist.sv
module kexp_assist
    import kexp_pkg::*;
#(
    parameter int ROT_BITS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] src_i,
    input  logic [IMM_W-1:0]   imm_i,
    output logic               done_o,
    output logic [BLOCK_W-1:0] result_o
);

    block_t src_blk;
    block_t next_blk;
    block_t res_q;
    logic   done_q;
    word_t  src_odd [NUM_LANES];
    word_t  sub_w   [NUM_LANES];
    word_t  mix_w   [NUM_LANES];

    assign src_blk    = block_t'(src_i);
    assign src_odd[0] = src_blk.w1;
    assign src_odd[1] = src_blk.w3;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        kexp_sub_word u_sub (
            .din  (src_odd[l]),
            .dout (sub_w[l])
        );
        kexp_rot_mix #(.ROT_BITS(ROT_BITS)) u_mix (
            .sub_i (sub_w[l]),
            .imm_i (imm_i),
            .mix_o (mix_w[l])
        );
    end

    always_comb begin
        next_blk.w0 = sub_w[0];
        next_blk.w1 = mix_w[0];
        next_blk.w2 = sub_w[1];
        next_blk.w3 = mix_w[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= start_i;
            if (start_i) res_q <= next_blk;
        end
    end

    assign done_o   = done_q;
    assign result_o = res_q;

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o); // R8
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(result_o)); // R9
    AST_LOW_WORD_MIX: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o[63:32] ==
            ({result_o[7:0], result_o[31:8]} ^ {24'h0, $past(imm_i)}))); // R4
    AST_HIGH_WORD_MIX: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o[127:96] ==
            ({result_o[71:64], result_o[95:72]} ^ {24'h0, $past(imm_i)}))); // R5

endmodule

// File: tb/kexp_assist_test.sv
module kexp_assist_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [127:0] src_i = '0;
    logic [7:0]   imm_i = '0;
    logic         done_o;
    logic [127:0] result_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    int exp_t[256];
    int log_t[256];

    bit           m_done;
    logic [127:0] m_res;
    logic [7:0]   rcon_q[$];

    always #5 clk = ~clk;

    kexp_assist uut (
        .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i),
        .imm_i(imm_i), .done_o(done_o), .result_o(result_o)
    );

    function automatic logic [7:0] rl(input logic [7:0] v, input int n);
        return 8'((v << n) | (v >> (8 - n)));
    endfunction

    function automatic logic [7:0] ref_sbox(input logic [7:0] a);
        logic [7:0] b;
        if (a == 0) b = 0;
        else b = 8'(exp_t[(255 - log_t[a]) % 255]);
        return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [127:0] ref_op(input logic [127:0] s, input logic [7:0] k);
        logic [127:0] r;
        for (int l = 0; l < 2; l++) begin
            logic [31:0] w;
            for (int b = 0; b < 4; b++)
                w[8*b +: 8] = ref_sbox(s[32*(2*l+1) + 8*b +: 8]);
            r[64*l +: 32]      = w;
            r[64*l + 32 +: 32] = {w[7:0], w[31:8]} ^ {24'h0, k};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // behavioural model, advanced at each clock edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_done = 0;
            m_res  = '0;
        end else begin
            m_done = start_i;
            if (start_i) m_res = ref_op(src_i, imm_i);
        end
    end

    always @(negedge clk) begin
        if (!rst && cycles > 0) begin
            check("R8 done per cycle", {127'h0, done_o}, {127'h0, m_done});
            check("R2 R3 R4 R5 R9 result per cycle", result_o, m_res);
        end
    end

    always @(posedge clk) begin
        if (cycles > 50000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic op(input logic [127:0] s, input logic [7:0] k);
        @(negedge clk);
        start_i = 1; src_i = s; imm_i = k;
        @(negedge clk);
        start_i = 0;
    endtask

    initial begin
        logic [127:0] key, r_a, r_b;
        logic [31:0]  t;
        int p;
        p = 1;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = p;
            log_t[p] = i;
            p = (p ^ (p << 1) ^ (((p >> 7) & 1) * 8'h1b)) & 8'hff;
        end
        log_t[0] = 0;

        repeat (3) @(negedge clk);
        check("R1 reset done", {127'h0, done_o}, 128'h0);
        check("R1 reset result", result_o, 128'h0);
        rst = 0;

        // R10 known S-box points: bytes 4..7 = 00,01,53,FF
        op({32'h0, 32'h0, 32'hff530100, 32'h0}, 8'h00);
        check("R10 sbox values", {96'h0, result_o[31:0]}, {96'h0, 32'h16ed7c63});
        check("R10 zero word", {96'h0, result_o[95:64]}, {96'h0, 32'h63636363});

        // R7 ignored bytes
        op(128'h0123_4567_0000_0000_89ab_cdef_0000_0000, 8'h1b);
        r_a = result_o;
        op(128'h0123_4567_dead_beef_89ab_cdef_5a5a_a5a5, 8'h1b);
        check("R7 ignored source bytes", result_o, r_a);

        // R6 immediate reach
        op(128'hfeed_f00d_1111_2222_c0ff_ee00_3333_4444, 8'h00);
        r_a = result_o;
        op(128'hfeed_f00d_1111_2222_c0ff_ee00_3333_4444, 8'hff);
        r_b = result_o;
        check("R6 imm-independent bits", r_b & ~{24'h0, 8'hff, 64'h0, 32'h0} & ~{88'h0, 8'hff, 32'h0},
              r_a & ~{24'h0, 8'hff, 64'h0, 32'h0} & ~{88'h0, 8'hff, 32'h0});
        check("R6 imm low bytes", {112'h0, r_b[103:96], r_b[39:32]},
              {112'h0, r_a[103:96] ^ 8'hff, r_a[39:32] ^ 8'hff});
        check("R4 word1 relation", {96'h0, r_b[63:32]}, {96'h0, {r_b[7:0], r_b[31:8]} ^ 32'hff});
        check("R5 word3 relation", {96'h0, r_b[127:96]}, {96'h0, {r_b[71:64], r_b[95:72]} ^ 32'hff});

        // R9 idle hold
        r_a = result_o;
        src_i = ~src_i; imm_i = 8'h5c;
        repeat (4) @(negedge clk);
        check("R9 hold while idle", result_o, r_a);
        check("R8 done low while idle", {127'h0, done_o}, 128'h0);

        // R8 back to back starts
        @(negedge clk);
        start_i = 1;
        for (int i = 0; i < 5; i++) begin
            src_i = {4{32'(i * 32'h01030507)}};
            imm_i = 8'(i);
            @(negedge clk);
            check("R8 back-to-back done", {127'h0, done_o}, 128'h1);
        end
        start_i = 0;
        @(negedge clk);

        // AES-128 key expansion, FIPS-197 example key
        rcon_q = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
        key = {8'h3c, 8'h4f, 8'hcf, 8'h09, 8'h88, 8'h15, 8'hf7, 8'hab,
               8'ha6, 8'hd2, 8'hae, 8'h28, 8'h16, 8'h15, 8'h7e, 8'h2b};
        for (int r = 1; r <= 10; r++) begin
            op(key, rcon_q.pop_front());
            t = result_o[127:96];
            key[31:0]   = key[31:0]   ^ t;
            key[63:32]  = key[63:32]  ^ key[31:0];
            key[95:64]  = key[95:64]  ^ key[63:32];
            key[127:96] = key[127:96] ^ key[95:64];
            if (r == 1)
                check("R3 R5 round key 1", key, {8'h05, 8'h76, 8'h6c, 8'h2a, 8'h39, 8'h39, 8'ha3, 8'h23,
                      8'hb1, 8'h2c, 8'h54, 8'h88, 8'h17, 8'hfe, 8'hfa, 8'ha0});
            if (r == 2)
                check("R3 R5 round key 2", key, {8'h7f, 8'hf6, 8'h59, 8'h73, 8'h7a, 8'h80, 8'h35, 8'h59,
                      8'h43, 8'hb9, 8'h96, 8'h7a, 8'hf2, 8'h95, 8'hc2, 8'hf2});
            if (r == 10)
                check("R3 R5 round key 10", key, {8'ha6, 8'h0c, 8'h63, 8'hb6, 8'hc8, 8'h0c, 8'h3f, 8'he1,
                      8'h89, 8'h25, 8'hee, 8'hc9, 8'ha8, 8'hf9, 8'h14, 8'hd0});
        end

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule